// File: doc/BRIEF.md
# Cascadable Unsigned Magnitude Comparator

This block compares two unsigned words, A and B, and reports on three output lines whether A is smaller than B, the same as B, or larger than B. Exactly one of the three lines is high at any time. The words are built from 4-bit groups, and the parameter `SLICES` sets how many groups there are. Each group may hold a plain binary value or a BCD digit; in both cases the comparison is the same unsigned one.

The logic is purely combinational. One 4-bit stage is generated per group. Each stage passes its three verdict lines to the cascade inputs of the next more significant stage. The lowest stage takes the block's own cascade inputs. For a standalone compare, tie these to smaller=0, same=1 and larger=1. To extend a compare across several instances, feed them from the verdict lines of a less significant instance.

Within a stage, the most significant unequal bit pair decides the result, and the lower bits and cascade inputs are then ignored. When a stage's two groups match, its verdict comes from the cascade inputs. The cascade-larger input is never consulted, and the larger output is high exactly when neither of the other two outputs is.

Top module: `magcmp_chain`

## Requirements
- R1: Exactly one of `lt_o`, `eq_o` and `gt_o` is 1 for every input combination.
- R2: When A and B differ, `lt_o` is 1 if A < B and `gt_o` is 1 if A > B, both as unsigned values, whatever the cascade inputs are.
- R3: When A equals B, `cas_lt_i`=1 and `cas_eq_i`=0, the outputs are lt=1, eq=0, gt=0.
- R4: When A equals B, `cas_lt_i`=0 and `cas_eq_i`=1, the outputs are lt=0, eq=1, gt=0.
- R5: When A equals B and both `cas_lt_i` and `cas_eq_i` are 0, the outputs are lt=0, eq=0, gt=1.
- R6: When A equals B and both `cas_lt_i` and `cas_eq_i` are 1, the smaller verdict wins: lt=1, eq=0, gt=0.
- R7: `cas_gt_i` has no effect on any output.
- R8: With the cascade inputs tied to lt=0, eq=1, gt=1, a chain of `SLICES` stages gives the unsigned compare of the full 4·`SLICES`-bit words. This includes words that differ only in bit 0 or only in the top bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | 4*SLICES | Word A, unsigned |
| opb_i | input | 4*SLICES | Word B, unsigned |
| cas_lt_i | input | 1 | Cascade input: lower part found A smaller |
| cas_eq_i | input | 1 | Cascade input: lower part found A equal |
| cas_gt_i | input | 1 | Cascade input: lower part found A larger (not used) |
| lt_o | output | 1 | A is smaller than B |
| eq_o | output | 1 | A equals B |
| gt_o | output | 1 | A is larger than B |

## Verification
The bench builds the block twice. One instance has `SLICES`=1, so all 16×16 nibble pairs can be swept against all eight cascade input patterns, including the contradictory ones and both values of the unused larger input. The second instance has `SLICES`=3 and its cascade inputs tied off for standalone use. It receives the corner words (all equal, differing in bit 0 only, differing in bit 11 only) and a few thousand random 12-bit pairs. This exercises the ripple of equal verdicts across stage boundaries.

// File: rtl/magcmp_chain.sv
module magcmp_chain #(
  parameter int SLICES = 3
) (
  input  logic [4*SLICES-1:0] opa_i,
  input  logic [4*SLICES-1:0] opb_i,
  input  logic                cas_lt_i,
  input  logic                cas_eq_i,
  input  logic                cas_gt_i,
  output logic                lt_o,
  output logic                eq_o,
  output logic                gt_o
);
  localparam int W = 4 * SLICES;

  // ripple[k] holds the verdict entering stage k; ripple[SLICES] is the result
  logic [SLICES:0] rip_lt, rip_eq, rip_gt;
  logic            unused_cas_gt;

  assign unused_cas_gt = cas_gt_i;
  assign rip_lt[0] = cas_lt_i;
  assign rip_eq[0] = cas_eq_i;
  assign rip_gt[0] = cas_gt_i;

  for (genvar k = 0; k < SLICES; k++) begin : g_stage
    logic [3:0] na, nb;
    logic       nib_lt, nib_same;
    assign na = opa_i[4*k +: 4];
    assign nb = opb_i[4*k +: 4];
    assign nib_same = (na == nb);
    // MSB-first: highest unequal pair decides
    assign nib_lt = (~na[3] & nb[3])
                  | ((na[3] ~^ nb[3]) & ~na[2] & nb[2])
                  | ((na[3] ~^ nb[3]) & (na[2] ~^ nb[2]) & ~na[1] & nb[1])
                  | ((na[3] ~^ nb[3]) & (na[2] ~^ nb[2]) & (na[1] ~^ nb[1]) & ~na[0] & nb[0]);
    assign rip_lt[k+1] = nib_lt | (nib_same & rip_lt[k]);
    assign rip_eq[k+1] = nib_same & ~rip_lt[k] & rip_eq[k];
    assign rip_gt[k+1] = ~rip_lt[k+1] & ~rip_eq[k+1];

    always_comb begin
      assert_stage_onehot_R1: assert ($countones({rip_lt[k+1], rip_eq[k+1], rip_gt[k+1]}) == 1)
        else $error("stage %0d verdict not one-hot", k);
    end
  end

  assign lt_o = rip_lt[SLICES];
  assign eq_o = rip_eq[SLICES];
  assign gt_o = rip_gt[SLICES];

  always_comb begin
    assert_onehot_R1: assert ($countones({lt_o, eq_o, gt_o}) == 1)
      else $error("result not one-hot");
    if (opa_i != opb_i) begin
      assert_differ_R2: assert (lt_o == (opa_i < opb_i) && gt_o == (opa_i > opb_i))
        else $error("unsigned order wrong");
    end
    if (opa_i == opb_i && !cas_lt_i && !cas_eq_i) begin
      assert_tie_gt_R5: assert (gt_o) else $error("equal words, no cascade: gt expected");
    end
    if (opa_i == opb_i && cas_lt_i) begin
      assert_tie_lt_R6: assert (lt_o) else $error("equal words, cascade lt: lt expected");
    end
    if (eq_o) begin
      assert_eq_src_R4: assert (opa_i == opb_i && cas_eq_i && !cas_lt_i)
        else $error("eq without equal words and cascade eq");
    end
  end

  logic [W-1:0] unused_w;
  assign unused_w = '0;
endmodule

// File: tb/sim_magcmp_chain.sv
module sim_magcmp_chain;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [11:0] a3, b3;
  logic        l3, e3, g3;
  logic [3:0]  a1, b1;
  logic        cl, ce, cg;
  logic        l1, e1, g1;

  magcmp_chain #(.SLICES(3)) u0 (
    .opa_i(a3), .opb_i(b3), .cas_lt_i(1'b0), .cas_eq_i(1'b1), .cas_gt_i(1'b1),
    .lt_o(l3), .eq_o(e3), .gt_o(g3));

  magcmp_chain #(.SLICES(1)) u1 (
    .opa_i(a1), .opb_i(b1), .cas_lt_i(cl), .cas_eq_i(ce), .cas_gt_i(cg),
    .lt_o(l1), .eq_o(e1), .gt_o(g1));

  task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got lt/eq/gt=%b expected %b", req, got, exp);
    end
  endtask

  function automatic logic [2:0] model(input int a, input int b, input bit lt, input bit eq);
    if (a < b) return 3'b100;
    if (a > b) return 3'b001;
    if (lt) return 3'b100;
    if (eq) return 3'b010;
    return 3'b001;
  endfunction

  task automatic drive3(input logic [11:0] a, input logic [11:0] b, input string req);
    @(negedge clk);
    a3 = a; b3 = b;
    #2;
    check(req, {l3, e3, g3}, model(int'(a), int'(b), 1'b0, 1'b1));
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    a3 = '0; b3 = '0; a1 = '0; b1 = '0; cl = 1'b0; ce = 1'b1; cg = 1'b1;
    repeat (2) @(negedge clk);
    check("R4 idle equal", {l3, e3, g3}, 3'b010);

    // exhaustive single stage, every cascade pattern
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        for (int c = 0; c < 8; c++) begin
          logic [2:0] exp;
          string req;
          @(negedge clk);
          a1 = a[3:0]; b1 = b[3:0];
          cl = c[2]; ce = c[1]; cg = c[0];
          #2;
          exp = model(a, b, c[2], c[1]);
          if (a != b)            req = "R2";
          else if (c[2] && !c[1]) req = "R3";
          else if (!c[2] && c[1]) req = "R4";
          else if (!c[2])         req = "R5";
          else                    req = "R6";
          check(req, {l1, e1, g1}, exp);
          check("R1", {2'b00, $countones({l1, e1, g1}) == 1}, 3'b001);
          if (c[0]) begin
            logic [2:0] with_gt;
            with_gt = {l1, e1, g1};
            cg = 1'b0;
            #2;
            check("R7", {l1, e1, g1}, with_gt);
          end
        end

    // 12-bit chain corners
    drive3(12'h000, 12'h000, "R8 zero equal");
    drive3(12'hFFF, 12'hFFF, "R8 ones equal");
    drive3(12'h5A3, 12'h5A3, "R8 equal");
    drive3(12'h5A2, 12'h5A3, "R8 lsb less");
    drive3(12'h5A3, 12'h5A2, "R8 lsb greater");
    drive3(12'h0FF, 12'h8FF, "R8 msb less");
    drive3(12'h8FF, 12'h0FF, "R8 msb greater");
    drive3(12'h7FF, 12'h800, "R8 msb vs rest");
    drive3(12'h800, 12'h7FF, "R8 msb vs rest rev");
    drive3(12'h0F0, 12'h100, "R8 mid stage");
    drive3(12'h999, 12'h998, "R8 bcd digits");
    for (int i = 0; i < 3000; i++) begin
      logic [11:0] ra, rb;
      ra = 12'($urandom);
      rb = (i % 5 == 0) ? ra ^ (12'h1 << (i % 12)) : 12'($urandom);
      drive3(ra, rb, "R8 random");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule